// File: doc/BRIEF.md
# Dual-Bank FSK Phase Accumulator Synthesizer

This block is a numerically controlled oscillator that produces the reference waveform for a narrow-band FSK transmitter. Software writes two 22-bit frequency words, one for each of two banks, an 8-bit deviation value and a small set of enables through a simple write port. A bank-select input chooses the active word without any rewriting, and a data input adds a deviation offset to the step while FSK keying is enabled.

A 24-bit phase accumulator advances by the selected step on every reference clock. The upper ten phase bits drive a quarter-wave sine shaper that returns 11-bit offset-binary samples for an external converter. When the active bank is switched off, or when the sleep input is high, the accumulator freezes and the sample output sits at mid-scale. The stored settings survive sleep and can still be written while asleep.

Top module: `nco_fsk_synth`

## Requirements
- R1: While reset is asserted and after it is released, the phase output is 0, the sample output is 1024, and all stored words and enables are 0, so the accumulator stays idle until written.
- R2: A write with `cfg_we` high stores `cfg_data` at the next clock edge according to `cfg_addr`: 0 loads the bank-0 word (bits 21..0), 1 the bank-1 word (bits 21..0), 2 the deviation (bits 7..0), 3 the enables (bit 0 bank-0 on, bit 1 bank-1 on, bit 2 FSK keying on).
- R3: While running, the phase grows by the step every clock, modulo 2^24; a change of inputs sampled at edge e sets the step that is added at edge e+1.
- R4: The step takes the bank word in bits 21..0 with bits 23..22 zero, so a bank word of 0x3FFFFF advances the phase by exactly 0x3FFFFF.
- R5: `bank_sel` low selects the bank-0 word and high selects the bank-1 word; switching banks never resets the phase.
- R6: With FSK keying on and `tx_bit` high the step is the bank word plus 4 times the deviation; with `tx_bit` low, or with keying off, `tx_bit` has no effect on the step.
- R7: While running, the sample output one clock after a phase value p equals round-to-table of 1023.5 + 1023·sin(2π·(p[23:14]+0.5)/1024), within ±2 codes.
- R8: When `sleep` is high or the selected bank's enable is 0, the phase holds its value and the sample output becomes 1024.
- R9: Stored words keep their values across sleep and may be written during sleep; the new value is used once running resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the settings |
| cfg_addr | input | 2 | Setting select: 0 bank-0 word, 1 bank-1 word, 2 deviation, 3 enables |
| cfg_data | input | 22 | Write data, right-aligned |
| bank_sel | input | 1 | Active bank: 0 or 1 |
| tx_bit | input | 1 | Keying data bit |
| sleep | input | 1 | High freezes the synthesizer |
| phase_o | output | 24 | Accumulator phase |
| amp_o | output | 11 | Offset-binary sine sample |

## Verification
An input or setting present at clock edge e reaches the step register at e, the phase at e+1 and the sample at e+2; a write lands at e and first shapes the step at e+1. The bench keeps a cycle model that, at every rising edge, pushes the phase and sample due after that edge into a queue, and a monitor pops one entry per falling edge and compares it with the ports, so every comparison lines up with its edge regardless of how long a stimulus lasts. Samples are compared against a real-valued sine with a two-code margin, and mid-scale idle values exactly.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int PHASE_W   = 24;
    localparam int WORD_W    = 22;
    localparam int DEV_W     = 8;
    localparam int DEV_SHIFT = 2;
    localparam int AMP_W     = 11;
    localparam int LUT_AW    = 8;
    localparam int SIN_IN_W  = LUT_AW + 2;

    typedef enum logic [1:0] {
        CFG_BANK0 = 2'd0,
        CFG_BANK1 = 2'd1,
        CFG_DEV   = 2'd2,
        CFG_CTRL  = 2'd3
    } cfg_addr_e;

    typedef struct packed {
        logic [WORD_W-1:0] word0;
        logic [WORD_W-1:0] word1;
        logic [DEV_W-1:0]  dev;
        logic              on0;
        logic              on1;
        logic              fsk_on;
    } cfg_t;
endpackage

// File: rtl/nco_cfg.sv
module nco_cfg
    import nco_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [WORD_W-1:0] data,
    output cfg_t              cfg_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (cfg_addr_e'(addr))
                CFG_BANK0: cfg_d.word0 = data;
                CFG_BANK1: cfg_d.word1 = data;
                CFG_DEV:   cfg_d.dev   = data[DEV_W-1:0];
                CFG_CTRL: begin
                    cfg_d.on0    = data[0];
                    cfg_d.on1    = data[1];
                    cfg_d.fsk_on = data[2];
                end
                default: cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    // R2: a deviation write lands on the following edge
    p_dev_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 2'd2) |=> (cfg_q.dev == $past(data[DEV_W-1:0])));
    // R9: without a write the settings never move
    p_retain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> (cfg_q == $past(cfg_q)));
endmodule

// File: rtl/nco_incr.sv
module nco_incr
    import nco_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  cfg_t               cfg,
    input  logic               bank_sel,
    input  logic               tx_bit,
    input  logic               sleep,
    output logic [PHASE_W-1:0] incr_o,
    output logic               run_o
);
    typedef struct packed {
        logic [PHASE_W-1:0] incr;
        logic               run;
    } step_t;

    step_t             st_d, st_q;
    logic [WORD_W-1:0] sel_word;
    logic [PHASE_W-1:0] dev_off;

    always_comb begin
        sel_word = bank_sel ? cfg.word1 : cfg.word0;
        dev_off  = PHASE_W'(cfg.dev) << DEV_SHIFT;
        st_d.incr = PHASE_W'(sel_word) + ((cfg.fsk_on && tx_bit) ? dev_off : '0);
        st_d.run  = !sleep && (bank_sel ? cfg.on1 : cfg.on0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign incr_o = st_q.incr;
    assign run_o  = st_q.run;

    // R4: the step never reaches the top phase bit
    p_top_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.incr[PHASE_W-1] == 1'b0);
    // R6: with keying off the data bit leaves the step at the bank word
    p_key_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.fsk_on |=> (st_q.incr == PHASE_W'($past(sel_word))));
    // R8: sleep always clears the run flag on the next edge
    p_sleep_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !st_q.run);
endmodule

// File: rtl/nco_sine.sv
module nco_sine
    import nco_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SIN_IN_W-1:0] phase_hi,
    input  logic                run,
    output logic [AMP_W-1:0]    amp_o
);
    localparam int  LUT_DEPTH = 2 ** LUT_AW;
    localparam int  MID       = 2 ** (AMP_W - 1);
    localparam real MAG       = real'(MID - 1);
    localparam real HALF_PI   = 1.5707963267948966;

    logic [AMP_W-2:0] lut [LUT_DEPTH];

    for (genvar g = 0; g < LUT_DEPTH; g++) begin : g_lut
        localparam real ANG = (real'(g) + 0.5) * HALF_PI / real'(LUT_DEPTH);
        localparam int  VAL = int'(MAG * $sin(ANG));
        assign lut[g] = VAL[AMP_W-2:0];
    end

    logic [1:0]        quad;
    logic [LUT_AW-1:0] idx;
    logic [AMP_W-1:0]  mag;
    logic [AMP_W-1:0]  amp_d, amp_q;

    always_comb begin
        quad = phase_hi[SIN_IN_W-1 -: 2];
        idx  = quad[0] ? ~phase_hi[LUT_AW-1:0] : phase_hi[LUT_AW-1:0];
        mag  = AMP_W'(lut[idx]);
        if (!run)         amp_d = AMP_W'(MID);
        else if (quad[1]) amp_d = AMP_W'(MID - 1) - mag;
        else              amp_d = AMP_W'(MID) + mag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) amp_q <= AMP_W'(MID);
        else        amp_q <= amp_d;
    end

    assign amp_o = amp_q;

    // R8: an idle cycle yields mid-scale
    p_idle_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (amp_q == AMP_W'(MID)));
    // R7: first half turn gives the upper half of the code range
    p_upper_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !phase_hi[SIN_IN_W-1]) |=> (amp_q >= AMP_W'(MID)));
    // R7: second half turn gives the lower half
    p_lower_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && phase_hi[SIN_IN_W-1]) |=> (amp_q < AMP_W'(MID)));
endmodule

// File: rtl/nco_fsk_synth.sv
module nco_fsk_synth
    import nco_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_addr,
    input  logic [WORD_W-1:0]  cfg_data,
    input  logic               bank_sel,
    input  logic               tx_bit,
    input  logic               sleep,
    output logic [PHASE_W-1:0] phase_o,
    output logic [AMP_W-1:0]   amp_o
);
    cfg_t               cfg;
    logic [PHASE_W-1:0] incr;
    logic               run;
    logic [PHASE_W-1:0] phase_d, phase_q;

    nco_cfg i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .data  (cfg_data),
        .cfg_o (cfg)
    );

    nco_incr i_incr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg),
        .bank_sel (bank_sel),
        .tx_bit   (tx_bit),
        .sleep    (sleep),
        .incr_o   (incr),
        .run_o    (run)
    );

    always_comb begin
        phase_d = run ? (phase_q + incr) : phase_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    nco_sine i_sine (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_hi (phase_q[PHASE_W-1 -: SIN_IN_W]),
        .run      (run),
        .amp_o    (amp_o)
    );

    assign phase_o = phase_q;

    // R8: idle freezes the phase
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(phase_q));
    // R3: running adds the registered step, wrapping modulo 2^24
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (phase_q == $past(phase_q) + $past(incr)));
endmodule

// File: tb/test_nco_fsk_synth.sv
module test_nco_fsk_synth;
    import nco_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [21:0] cfg_data = '0;
    logic        bank_sel = 1'b0;
    logic        tx_bit = 1'b0;
    logic        sleep = 1'b0;
    logic [23:0] phase_o;
    logic [10:0] amp_o;

    always #2 clk = ~clk;

    nco_fsk_synth i_nco_fsk_synth (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .bank_sel(bank_sel), .tx_bit(tx_bit),
        .sleep(sleep), .phase_o(phase_o), .amp_o(amp_o)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    typedef struct {
        int unsigned ph;
        bit          mid;
        int          p10;
        string       req;
    } exp_t;
    exp_t sb[$];

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // reference model: settings, step, run flag and phase
    int unsigned m_w0, m_w1, m_dev, m_incr, m_phase;
    bit          m_on0, m_on1, m_fsk, m_run;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_w0 = 0; m_w1 = 0; m_dev = 0; m_incr = 0; m_phase = 0;
            m_on0 = 0; m_on1 = 0; m_fsk = 0; m_run = 0;
            sb.delete();
        end else begin
            exp_t        e;
            int unsigned nph;
            e.mid = !m_run;
            e.p10 = int'(m_phase >> 14);
            nph   = m_run ? ((m_phase + m_incr) & 32'h00FF_FFFF) : m_phase;
            m_incr = (bank_sel ? m_w1 : m_w0) + ((m_fsk && tx_bit) ? (m_dev * 4) : 0);
            m_run  = !sleep && (bank_sel ? m_on1 : m_on0);
            if (cfg_we) begin
                case (cfg_addr)
                    2'd0: m_w0 = cfg_data;
                    2'd1: m_w1 = cfg_data;
                    2'd2: m_dev = cfg_data & 22'hFF;
                    default: begin
                        m_on0 = cfg_data[0];
                        m_on1 = cfg_data[1];
                        m_fsk = cfg_data[2];
                    end
                endcase
            end
            m_phase = nph;
            e.ph  = nph;
            e.req = cur_req;
            sb.push_back(e);
        end
    end

    // monitor: one expected item per falling edge
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0 && !done) begin
            exp_t e;
            real  tgt, diff;
            e = sb.pop_front();
            chk(phase_o == e.ph[23:0], e.req, "phase", phase_o, e.ph);
            if (e.mid) begin
                chk(amp_o == 11'd1024, e.req, "idle sample", amp_o, 1024);
            end else begin
                tgt  = 1023.5 + 1023.0 * $sin(2.0 * 3.141592653589793 * (real'(e.p10) + 0.5) / 1024.0);
                diff = real'(amp_o) - tgt;
                chk(diff <= 2.0 && diff >= -2.0, e.req, "sine sample", amp_o, longint'(tgt));
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'(a); cfg_data = 22'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(phase_o == 24'd0, "R1", "phase in reset", phase_o, 0);
        chk(amp_o == 11'd1024, "R1", "sample in reset", amp_o, 1024);
        rst_n = 1'b1;
        cur_req = "R1";
        idle(6);

        cur_req = "R2";
        wr(0, 22'h012345);
        wr(1, 22'h3FFFFF);
        wr(2, 8'h80);
        wr(3, 3'b011);
        cur_req = "R3";
        idle(40);

        cur_req = "R4";
        bank_sel = 1'b1;
        idle(30);
        cur_req = "R5";
        bank_sel = 1'b0;
        idle(10);
        bank_sel = 1'b1;
        idle(10);

        cur_req = "R6";
        for (int i = 0; i < 12; i++) begin
            tx_bit = ~tx_bit;
            idle(2);
        end
        wr(3, 3'b111);
        for (int i = 0; i < 16; i++) begin
            tx_bit = ~tx_bit;
            idle(3);
        end
        tx_bit = 1'b0;

        cur_req = "R7";
        bank_sel = 1'b0;
        wr(0, 22'h040000);
        idle(80);

        cur_req = "R8";
        sleep = 1'b1;
        idle(8);
        cur_req = "R9";
        wr(0, 22'h00ABCD);
        idle(4);
        sleep = 1'b0;
        idle(20);

        cur_req = "R8";
        bank_sel = 1'b1;
        wr(3, 3'b001);
        idle(12);
        bank_sel = 1'b0;
        cur_req = "R5";
        idle(12);

        idle(4);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule